// File: doc/BRIEF.md
# Byte-Serial SPI Master with Completion and Collision Flags

This block is a byte-at-a-time SPI master for a CPU's peripheral bus. Software sets up a control register, then writes a byte to the data register. If the block is enabled, in master mode and idle, the byte is shifted out on MOSI, most significant bit first. At the same time a byte is gathered from MISO, and it can be read back from the data register once the shift ends. The SCK rate comes from the system clock. Two rate bits in the control register and a double-speed bit in the status register pick one of eight divisors.

The status register holds two sticky flags. One marks that a transfer is complete and the other marks a write collision. Software clears them with a fixed handshake: it reads the status register while a flag is set and then accesses the data register. An interrupt acknowledge also clears the completion flag. A falling edge on the SS pin can be watched as a mode-fault input, and while the block acts as master such an edge raises the completion flag. The interrupt request is the completion flag gated by the interrupt-enable bit.

Top module: `spim_stat`

## Requirements
- R1: The SCK period, in system clock cycles, follows the 3-bit index {double-speed, rate[1], rate[0]}: 000→4, 001→16, 010→64, 011→128, 100→2, 101→8, 110→32, 111→64.
- R2: A transfer shifts 8 bits MSB first. SCK idles low. MOSI changes after a falling SCK edge and MISO is sampled on the rising edge. After completion, a read of the data register returns the byte received.
- R3: When the master bit is clear, a data write starts no transfer and SCK stays low whatever the rate bits are. The written byte is still stored and can be read back from the data register.
- R4: The completion flag (status bit 7) is set at the end of a transfer. The irq output equals that flag ANDed with control bit 7. With control bit 7 clear, irq stays low.
- R5: A one-cycle irq_ack pulse clears the completion flag. A set event in the same cycle takes priority.
- R6: A status read made while the completion flag or the collision flag (status bit 6) is set arms a clear. The next data-register access (read or write) then clears both flags.
- R7: A data-register access with no armed status read leaves both flags set.
- R8: A data write while a transfer is running sets the collision flag. That write is discarded, and the running transfer completes with its original byte.
- R9: A high-to-low edge on ss_n sets the completion flag when control bits 6 (enable), 4 (master) and 2 (SS watch) are all set. With bit 2 clear, the edge has no effect.
- R10: A flag-set event that occurs after the arming status read cancels the arming, so the following data access leaves the flags set.
- R11: Register map by reg_addr: 0 control, 1 status, 2 data, 3 reads zero. Status bits 5 to 1 always read zero. Bit 0 is the double-speed bit and is read/write. Status writes change only bit 0. Control is a plain 8-bit register with fields rate [1:0], SS watch [2], master [4], enable [6] and interrupt enable [7]. Control and status reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | DATA_W | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_rdata | output | DATA_W | Read data, combinational from reg_addr |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | input | 1 | Slave-select pin, watched for mode faults |

## Verification
The properties assume that each register access is a one-cycle strobe to a single address, with read and write never asserted together. They also assume irq_ack is a single-cycle pulse and that the rate bits do not change during a shift. The stimulus meets these conditions. Every access is driven on the falling clock edge and held for exactly one cycle. MISO is looped back from MOSI, so it is stable at every rising SCK edge. ss_n is only pulsed while the control register is already set up. The rate index is rewritten only between transfers.

// File: rtl/spim_pkg.sv
package spim_pkg;

   localparam int MAX_HALF_LOG2 = 6;

   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_STAT = 2'd1,
      REG_DATA = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;

   localparam int CTL_RATE_LO = 0;
   localparam int CTL_SSWATCH = 2;
   localparam int CTL_MASTER  = 4;
   localparam int CTL_ENABLE  = 6;
   localparam int CTL_IRQEN   = 7;

   // log2 of half the SCK period for index {dbl, rate[1:0]}
   function automatic int half_log2(input logic [2:0] sel);
      int full;
      full = (sel[1:0] == 2'd3) ? 7 : (2 + 2 * int'(sel[1:0]));
      if (sel[2]) full = full - 1;
      return full - 1;
   endfunction

endpackage

// File: rtl/spim_sckgen.sv
module spim_sckgen #(
   parameter int CNT_W = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [2:0] sel,
   output logic       sck,
   output logic       rise_p,
   output logic       fall_p
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;
   logic             wrap;

   always_comb begin
      lim = CNT_W'((32'd1 << spim_pkg::half_log2(sel)) - 32'd1);
   end

   assign wrap   = run && (cnt >= lim);
   assign rise_p = wrap && !sck;
   assign fall_p = wrap && sck;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sck <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         sck <= 1'b0;
      end else if (wrap) begin
         cnt <= '0;
         sck <= ~sck;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic         go,
   input  logic [W-1:0] load,
   input  logic         rise_p,
   input  logic         fall_p,
   input  logic         miso,
   output logic         busy,
   output logic         mosi,
   output logic [W-1:0] shreg,
   output logic         done_p
);
   localparam int BCW = (W > 1) ? $clog2(W) : 1;
   localparam logic [BCW-1:0] LAST = BCW'(W - 1);

   logic [BCW-1:0] bcnt;

   assign done_p = busy && fall_p && (bcnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         mosi  <= 1'b0;
         busy  <= 1'b0;
         bcnt  <= '0;
      end else if (ld) begin
         shreg <= load;
         if (go) begin
            mosi <= load[W-1];
            busy <= 1'b1;
            bcnt <= '0;
         end
      end else if (busy) begin
         if (rise_p) shreg <= {shreg[W-2:0], miso};
         if (fall_p) begin
            mosi <= shreg[W-1];
            if (bcnt == LAST) busy <= 1'b0;
            else              bcnt <= bcnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/spim_flags.sv
module spim_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic xfer_done,
   input  logic fault,
   input  logic coll,
   input  logic stat_rd,
   input  logic data_acc,
   input  logic irq_ack,
   output logic done_q,
   output logic wcol_q
);
   logic armed_q;
   logic set_done;
   logic clr;

   assign set_done = xfer_done || fault;
   assign clr      = data_acc && armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         wcol_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (set_done)            done_q <= 1'b1;
         else if (clr || irq_ack) done_q <= 1'b0;

         if (coll)     wcol_q <= 1'b1;
         else if (clr) wcol_q <= 1'b0;

         if (set_done || coll)                    armed_q <= 1'b0;
         else if (stat_rd && (done_q || wcol_q))  armed_q <= 1'b1;
         else if (data_acc)                       armed_q <= 1'b0;
      end
   end
endmodule

// File: rtl/spim_stat.sv
module spim_stat #(
   parameter int DATA_W  = 8,
   parameter int SS_SYNC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_wr,
   input  logic              reg_rd,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              irq_ack,
   output logic              irq,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   input  logic              ss_n
);
   import spim_pkg::*;

   localparam int CNT_W = MAX_HALF_LOG2;

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("spim_stat: DATA_W must be at least 8");
      end
      if (SS_SYNC < 0 || SS_SYNC > 3) begin : g_bad_sync
         $error("spim_stat: SS_SYNC must be 0 to 3");
      end
   endgenerate

   logic [7:0]        ctrl_q;
   logic              dbl_q;
   logic              busy;
   logic              rise_p;
   logic              fall_p;
   logic              xfer_done;
   logic              fault_p;
   logic              done_q;
   logic              wcol_q;
   logic [DATA_W-1:0] shreg;
   logic              ss_s;
   logic              ss_prev;

   logic wr_ctrl, wr_stat, wr_data, stat_rd, data_acc, go, ld, coll;
   logic master_on;

   assign wr_ctrl  = reg_wr && (reg_addr == REG_CTRL);
   assign wr_stat  = reg_wr && (reg_addr == REG_STAT);
   assign wr_data  = reg_wr && (reg_addr == REG_DATA);
   assign stat_rd  = reg_rd && (reg_addr == REG_STAT);
   assign data_acc = (reg_wr || reg_rd) && (reg_addr == REG_DATA);

   assign master_on = ctrl_q[CTL_ENABLE] && ctrl_q[CTL_MASTER];
   assign ld   = wr_data && !busy;
   assign go   = ld && master_on;
   assign coll = wr_data && busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         dbl_q  <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= reg_wdata[7:0];
         if (wr_stat) dbl_q  <= reg_wdata[0];
      end
   end

   // SS input conditioning: direct or through a synchronizer chain
   generate
      if (SS_SYNC == 0) begin : g_ss_direct
         assign ss_s = ss_n;
      end else begin : g_ss_sync
         logic [SS_SYNC-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '1;
            else        sr <= SS_SYNC'({sr, ss_n});
         end
         assign ss_s = sr[SS_SYNC-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ss_prev <= 1'b1;
      else        ss_prev <= ss_s;
   end

   assign fault_p = master_on && ctrl_q[CTL_SSWATCH] && ss_prev && !ss_s;

   spim_sckgen #(.CNT_W(CNT_W)) u_sckgen (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (busy),
      .sel    ({dbl_q, ctrl_q[CTL_RATE_LO+1], ctrl_q[CTL_RATE_LO]}),
      .sck    (sck),
      .rise_p (rise_p),
      .fall_p (fall_p)
   );

   spim_shift #(.W(DATA_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (ld),
      .go     (go),
      .load   (reg_wdata),
      .rise_p (rise_p),
      .fall_p (fall_p),
      .miso   (miso),
      .busy   (busy),
      .mosi   (mosi),
      .shreg  (shreg),
      .done_p (xfer_done)
   );

   spim_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .xfer_done (xfer_done),
      .fault     (fault_p),
      .coll      (coll),
      .stat_rd   (stat_rd),
      .data_acc  (data_acc),
      .irq_ack   (irq_ack),
      .done_q    (done_q),
      .wcol_q    (wcol_q)
   );

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         REG_CTRL: reg_rdata = DATA_W'(ctrl_q);
         REG_STAT: begin
            reg_rdata[DATA_W-1] = done_q;
            reg_rdata[DATA_W-2] = wcol_q;
            reg_rdata[0]        = dbl_q;
         end
         REG_DATA: reg_rdata = shreg;
         default:  reg_rdata = '0;
      endcase
   end

   assign irq = done_q && ctrl_q[CTL_IRQEN];

endmodule

// File: rtl/spim_stat_chk.sv
module spim_stat_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              sck,
   input logic              wr_data,
   input logic              wcol,
   input logic              irq_ack,
   input logic              set_evt,
   input logic              done,
   input logic              stat_rd,
   input logic [DATA_W-1:0] rdata
);
   // R2
   sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck);

   // R8
   collision_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && busy) |=> wcol);

   // R5
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !set_evt) |=> !done);

   // R4
   done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(set_evt));

   // R11
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |-> (rdata[DATA_W-3:1] == '0));
endmodule

bind spim_stat spim_stat_chk #(.DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .sck     (sck),
   .wr_data (wr_data),
   .wcol    (wcol_q),
   .irq_ack (irq_ack),
   .set_evt (xfer_done || fault_p),
   .done    (done_q),
   .stat_rd (stat_rd),
   .rdata   (reg_rdata)
);

// File: tb/spim_stat_tb.sv
module spim_stat_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_rdata;
   logic       irq_ack = 1'b0;
   logic       irq;
   logic       sck;
   logic       mosi;
   logic       miso;
   logic       ss_n = 1'b1;

   int nchk = 0;
   int nerr = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   assign miso = mosi;

   spim_stat u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
      .irq_ack(irq_ack), .irq(irq), .sck(sck), .mosi(mosi), .miso(miso),
      .ss_n(ss_n)
   );

   // {index[2:0] at 10:8, expected period at 7:0}
   localparam logic [15:0] VEC [8] = '{
      {5'd0, 3'b000, 8'd4},   {5'd0, 3'b001, 8'd16},
      {5'd0, 3'b010, 8'd64},  {5'd0, 3'b011, 8'd128},
      {5'd0, 3'b100, 8'd2},   {5'd0, 3'b101, 8'd8},
      {5'd0, 3'b110, 8'd32},  {5'd0, 3'b111, 8'd64}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wait_irq(output bit ok);
      ok = 0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (irq) begin ok = 1; break; end
      end
   endtask

   // watch a running transfer: period between first two rises and MOSI bits at rises
   task automatic watch(output int period, output logic [7:0] bits);
      int cyc = 0, r1 = -1, r2 = -1, nr = 0;
      logic p = 1'b0;
      bits = '0;
      while (nr < 8 && cyc < 3000) begin
         @(negedge clk);
         cyc++;
         if (sck && !p) begin
            nr++;
            bits = {bits[6:0], mosi};
            if (nr == 1) r1 = cyc;
            if (nr == 2) r2 = cyc;
         end
         p = sck;
      end
      period = r2 - r1;
   endtask

   task automatic ss_pulse();
      @(negedge clk); ss_n = 1'b0;
      @(negedge clk); @(negedge clk); ss_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   initial begin
      for (int i = 0; i < 200000; i++) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] d;
      logic [7:0] bits;
      int per;
      bit ok;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      rd(2'd0, d); check("R11 ctrl reset", d, 8'h00);
      rd(2'd1, d); check("R11 status reset", d, 8'h00);
      check("R4 irq reset", {7'd0, irq}, 8'h00);
      check("R2 sck reset", {7'd0, sck}, 8'h00);

      // R1 / R2 / R6: every rate index
      for (int i = 0; i < 8; i++) begin
         logic [2:0] sel;
         logic [7:0] tx;
         sel = VEC[i][10:8];
         tx  = 8'hA5 ^ 8'(i * 37);
         wr(2'd0, 8'hD0 | {6'd0, sel[1:0]});
         wr(2'd1, {7'd0, sel[2]});
         wr(2'd2, tx);
         watch(per, bits);
         check("R1 sck period", 8'(per), VEC[i][7:0]);
         check("R2 mosi msb first", bits, tx);
         wait_irq(ok);
         check("R4 irq after transfer", {7'd0, ok}, 8'h01);
         rd(2'd1, d); check("R4 done set", d, {1'b1, 6'd0, sel[2]});
         rd(2'd2, d); check("R2 received byte", d, tx);
         rd(2'd1, d); check("R6 flags cleared", d, {7'd0, sel[2]});
         check("R6 irq low", {7'd0, irq}, 8'h00);
      end

      // fastest setting for the directed tests
      wr(2'd0, 8'hD0);
      wr(2'd1, 8'h01);

      // R7: data access without prior status read
      wr(2'd2, 8'h11);
      wait_irq(ok);
      rd(2'd2, d);
      rd(2'd1, d); check("R7 flag kept", d, 8'h81);
      rd(2'd2, d);
      rd(2'd1, d); check("R6 cleared after arm", d, 8'h01);

      // R5: interrupt acknowledge
      wr(2'd2, 8'h22);
      wait_irq(ok);
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      check("R5 irq after ack", {7'd0, irq}, 8'h00);
      rd(2'd1, d); check("R5 done after ack", d, 8'h01);

      // R8: collision during a transfer
      wr(2'd2, 8'h3C);
      repeat (3) @(negedge clk);
      wr(2'd2, 8'hFF);
      wait_irq(ok);
      rd(2'd1, d); check("R8 collision flag", d, 8'hC1);
      rd(2'd2, d); check("R8 original byte", d, 8'h3C);
      rd(2'd1, d); check("R6 both cleared", d, 8'h01);

      // R10: new event between read and access
      wr(2'd0, 8'hD4);
      wr(2'd2, 8'h5A);
      wait_irq(ok);
      rd(2'd1, d);
      ss_pulse();
      rd(2'd2, d);
      rd(2'd1, d); check("R10 rearmed, flag kept", d, 8'h81);
      rd(2'd2, d);
      rd(2'd1, d); check("R10 cleared on second pass", d, 8'h01);

      // R9: mode fault
      ss_pulse();
      rd(2'd1, d); check("R9 fault sets done", d, 8'h81);
      check("R9 irq on fault", {7'd0, irq}, 8'h01);
      rd(2'd2, d);
      wr(2'd0, 8'hD0);
      ss_pulse();
      rd(2'd1, d); check("R9 unwatched ss ignored", d, 8'h01);
      check("R9 irq stays low", {7'd0, irq}, 8'h00);

      // R4: interrupt enable clear
      wr(2'd0, 8'h50);
      wr(2'd2, 8'h77);
      repeat (40) @(negedge clk);
      check("R4 irq masked", {7'd0, irq}, 8'h00);
      rd(2'd1, d); check("R4 done without irq", d, 8'h81);
      rd(2'd2, d);

      // R3: slave mode does not shift
      begin
         int hi = 0;
         wr(2'd0, 8'hC3);
         wr(2'd2, 8'h96);
         for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (sck) hi++;
         end
         check("R3 sck idle in slave", 8'(hi), 8'h00);
         rd(2'd1, d); check("R3 no completion", d, 8'h01);
         rd(2'd2, d); check("R3 byte stored", d, 8'h96);
      end

      // R11: status write affects only bit 0
      wr(2'd1, 8'hFF);
      rd(2'd1, d); check("R11 status write mask", d, 8'h01);
      wr(2'd1, 8'h00);
      rd(2'd1, d); check("R11 dbl cleared", d, 8'h00);
      rd(2'd3, d); check("R11 unused address", d, 8'h00);

      finish_run();
   end
endmodule